// File: doc/BRIEF.md
# Contact Lockout Debouncer

This block cleans up the level from a mechanical key or paddle contact so that downstream keying logic sees one clean transition per closure and one per release. The raw contact is pulled up, so it reads high while the key is open and low while it is pressed. The raw level is first brought into the clock domain by a two-stage synchronizer. The output is a registered set/reset latch driven by two one-shot timers.

The make timer handles closures and the break timer handles releases. The first disagreement between the synchronized contact and the latch starts the matching timer and flips the latch at once, so there is no settle delay before the output responds. While either timer runs, the latch is frozen and the other timer cannot start, so contact chatter in that window has no effect. When the lockout ends, a contact that has settled at the opposite level is taken up on the very next clock edge. The lockout length is the parameter `LOCK_CYCLES`, counted in clock cycles. A few milliseconds suits hand-sent code: about 4 ms fits the element lengths of a semi-automatic key.

Top module: `contact_debouncer`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it is released, `key_open` is 1 (key open) and no lockout is running.
- R2: When `contact_raw` goes from 1 to 0 while the output is 1 and no lockout is running, `key_open` becomes 0 on the third rising clock edge after the change. That edge is the first one at which the input is sampled, plus two more.
- R3: When `contact_raw` goes from 0 to 1 while the output is 0 and no lockout is running, `key_open` becomes 1 on the third rising clock edge after the change.
- R4: For the `LOCK_CYCLES` clock edges that follow any change of `key_open`, the output holds its value whatever `contact_raw` does. A closure starts only the make timer and a release starts only the break timer, and the two timers never run together.
- R5: Once a lockout has ended, if the synchronized contact level differs from `key_open`, the output takes that level on the next clock edge. A contact that reverts during a lockout therefore flips the output exactly `LOCK_CYCLES`+1 edges after the previous flip.
- R6: `key_open` never changes while the synchronized contact level already equals it.
- R7: Every output level, once entered after reset, lasts at least `LOCK_CYCLES`+1 clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| contact_raw | input | 1 | Raw contact level, asynchronous; 1 = open, 0 = closed |
| key_open | output | 1 | Debounced level; 1 = key open, 0 = key closed |

## Verification
A timer that fails to block shows up at the ports as an output that flips again within `LOCK_CYCLES` cycles of its last flip. This is caught on the first chatter burst after a transition. A timer that never clears freezes the output, which shows one cycle after the expected post-lockout flip. An extra or missing synchronizer stage moves every transition by one edge, so the exact-latency checks catch it on the first clean closure. The bench compares every cycle against a cycle-level model built from the requirements, so a wrong internal state is reported in the cycle in which it first reaches `key_open`.

// File: rtl/lockout_pkg.sv
// Package: shared definitions for the contact lockout debouncer.
// Assumes the contact is pulled up: 1 means open, 0 means pressed.
package lockout_pkg;

    // Contact and output level encoding.
    typedef enum logic {
        LVL_CLOSED = 1'b0,
        LVL_OPEN   = 1'b1
    } contact_lvl_e;

    // Index of each one-shot timer in the timer array.
    localparam int unsigned TMR_MAKE  = 0;
    localparam int unsigned TMR_BREAK = 1;
    localparam int unsigned TMR_COUNT = 2;

    // Width of a down-counter that must hold the value n.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/lockout_sync.sv
// Module: lockout_sync
// Multi-stage synchronizer for an asynchronous level.
// Assumes STAGES >= 2. Each stage resets to RESET_VAL so that reset
// never shows a false transition downstream.
module lockout_sync #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/lockout_oneshot.sv
// Module: lockout_oneshot
// Non-retriggerable one-shot timer. A fire pulse while the timer is idle
// loads LOCK_CYCLES; busy stays high until the count reaches zero.
// Assumes the caller only fires while idle; a fire while busy is ignored.
module lockout_oneshot #(
    parameter int unsigned LOCK_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic busy
);

    import lockout_pkg::*;

    localparam int unsigned CW = cnt_width(LOCK_CYCLES);

    logic [CW-1:0] remain;

    // Load on fire when idle, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end else if (fire) begin
            remain <= CW'(LOCK_CYCLES);
        end
    end

    assign busy = (remain != '0);

endmodule

// File: rtl/lockout_latch.sv
// Module: lockout_latch
// Registered set/reset latch holding the debounced level.
// Assumes set and clear are never asserted together; clear wins if they are.
module lockout_latch #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);

    // Hold the level, set by the break timer and cleared by the make timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= RESET_VAL;
        end else if (clr_i) begin
            q <= 1'b0;
        end else if (set_i) begin
            q <= 1'b1;
        end
    end

endmodule

// File: rtl/contact_debouncer.sv
// Module: contact_debouncer (top)
// Debounces a key contact on both closure and release. The first
// disagreement between the synchronized contact and the output flips the
// output at once and starts a lockout of LOCK_CYCLES clocks, during which
// the other direction is blocked and chatter is ignored.
// Assumes contact_raw is asynchronous, 1 = open and 0 = closed.
module contact_debouncer #(
    parameter int unsigned LOCK_CYCLES = 500000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic contact_raw,
    output logic key_open
);

    import lockout_pkg::*;

    logic                 sync_lvl;
    logic [TMR_COUNT-1:0] fire;
    logic [TMR_COUNT-1:0] busy;
    logic                 any_busy;
    logic [TMR_COUNT-1:0] want;

    lockout_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (LVL_OPEN)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (contact_raw),
        .sync_out (sync_lvl)
    );

    assign any_busy = |busy;

    // Which timer the current contact level asks for, given the output.
    always_comb begin
        want            = '0;
        want[TMR_MAKE]  = (sync_lvl == LVL_CLOSED) && (key_open == LVL_OPEN);
        want[TMR_BREAK] = (sync_lvl == LVL_OPEN)   && (key_open == LVL_CLOSED);
    end

    // One timer per direction; each fires only while neither timer runs.
    for (genvar g = 0; g < TMR_COUNT; g++) begin : g_tmr
        assign fire[g] = want[g] && !any_busy;

        lockout_oneshot #(
            .LOCK_CYCLES (LOCK_CYCLES)
        ) u_oneshot (
            .clk   (clk),
            .rst_n (rst_n),
            .fire  (fire[g]),
            .busy  (busy[g])
        );
    end

    lockout_latch #(
        .RESET_VAL (LVL_OPEN)
    ) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (fire[TMR_BREAK]),
        .clr_i (fire[TMR_MAKE]),
        .q     (key_open)
    );

endmodule

// File: rtl/contact_debouncer_checker.sv
// Module: contact_debouncer_checker
// Temporal checks for contact_debouncer, attached with bind.
// Assumes LOCK_CYCLES >= 1; the minimum hold time is tracked with a
// saturating counter rather than a long $past.
module contact_debouncer_checker #(
    parameter int unsigned LOCK_CYCLES = 500000
) (
    input logic clk,
    input logic rst_n,
    input logic key_open,
    input logic sync_lvl,
    input logic make_busy,
    input logic break_busy
);

    localparam int unsigned HOLD_MAX = LOCK_CYCLES + 1;
    localparam int unsigned HW       = $clog2(HOLD_MAX + 1);

    logic [HW-1:0] hold;
    logic          prev_q;

    // Count edges since the output last changed, saturating at HOLD_MAX.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
            hold   <= HW'(HOLD_MAX);
        end else begin
            prev_q <= key_open;
            if (key_open != prev_q) begin
                hold <= HW'(1);
            end else if (hold != HW'(HOLD_MAX)) begin
                hold <= hold + 1'b1;
            end
        end
    end

    p_reset_open_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (key_open && !make_busy && !break_busy));

    p_close_uses_make_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(key_open) |-> (make_busy && !break_busy));

    p_open_uses_break_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_open) |-> (break_busy && !make_busy));

    p_timers_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(make_busy && break_busy));

    p_frozen_in_lock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (make_busy || break_busy) |=> $stable(key_open));

    p_follow_after_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!make_busy && !break_busy && (sync_lvl != key_open)) |=> (key_open == $past(sync_lvl)));

    p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_lvl == key_open) |=> $stable(key_open));

    p_min_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_open) |-> (hold >= HW'(HOLD_MAX)));

endmodule

bind contact_debouncer contact_debouncer_checker #(
    .LOCK_CYCLES (LOCK_CYCLES)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_open   (key_open),
    .sync_lvl   (sync_lvl),
    .make_busy  (busy[0]),
    .break_busy (busy[1])
);

// File: tb/contact_debouncer_bench.sv
// Bench for contact_debouncer: directed corner cases, then seeded random
// chatter, each cycle compared with a model built from the requirements.
module contact_debouncer_bench;

    localparam int unsigned LOCK = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic contact_raw = 1'b1;
    logic key_open;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit cmp_on = 1'b0;

    always #4 clk = ~clk;

    contact_debouncer #(
        .LOCK_CYCLES (LOCK),
        .SYNC_STAGES (2)
    ) u_contact_debouncer (
        .clk         (clk),
        .rst_n       (rst_n),
        .contact_raw (contact_raw),
        .key_open    (key_open)
    );

    // Expected-value model: two-edge sampling delay, then the output follows
    // the sampled level whenever no lockout of LOCK edges is running.
    logic m_s1, m_s2, m_q;
    int   m_lock;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_q <= 1'b1; m_lock <= 0;
        end else begin
            m_s1 <= contact_raw;
            m_s2 <= m_s1;
            if (m_lock != 0) begin
                m_lock <= m_lock - 1;
            end else if (m_s2 != m_q) begin
                m_q    <= m_s2;
                m_lock <= LOCK;
            end
        end
    end

    function automatic bit min_hold_ok(input int run);
        return run >= int'(LOCK) + 1;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle comparison with the model, plus the minimum hold time.
    int  run = 0;
    bit  seen_change = 1'b0;
    logic last_q = 1'b1;
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check(key_open === m_q, "R5 model", int'(key_open), int'(m_q));
            if (key_open !== last_q) begin
                if (seen_change)
                    check(min_hold_ok(run), "R7 min hold", run, int'(LOCK) + 1);
                seen_change = 1'b1;
                run = 1;
            end else begin
                run++;
            end
            last_q = key_open;
        end
    end

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1D0C_7E55));
        // R1: reset state
        repeat (3) @(negedge clk);
        check(key_open === 1'b1, "R1 in reset", int'(key_open), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(key_open === 1'b1, "R1 after reset", int'(key_open), 1);
        cmp_on = 1'b1;
        wait_edges(4);

        // R2: clean closure, exact latency of three edges
        contact_raw = 1'b0;
        wait_edges(2);
        check(key_open === 1'b1, "R2 before third edge", int'(key_open), 1);
        wait_edges(1);
        check(key_open === 1'b0, "R2 third edge", int'(key_open), 0);

        // R4: chatter during lockout is ignored
        for (int i = 0; i < int'(LOCK) - 3; i++) begin
            contact_raw = ~contact_raw;
            wait_edges(1);
            check(key_open === 1'b0, "R4 chatter ignored", int'(key_open), 0);
        end
        contact_raw = 1'b0;
        // R6: settled contact agrees, output must stay
        wait_edges(3 * int'(LOCK));
        check(key_open === 1'b0, "R6 steady closed", int'(key_open), 0);

        // R3: clean release, exact latency
        contact_raw = 1'b1;
        wait_edges(2);
        check(key_open === 1'b0, "R3 before third edge", int'(key_open), 0);
        wait_edges(1);
        check(key_open === 1'b1, "R3 third edge", int'(key_open), 1);
        wait_edges(2 * int'(LOCK));
        check(key_open === 1'b1, "R6 steady open", int'(key_open), 1);

        // R5: one-cycle closure glitch, output low, then high LOCK+1 edges later
        contact_raw = 1'b0;
        @(negedge clk);
        contact_raw = 1'b1;
        wait_edges(2);
        check(key_open === 1'b0, "R5 glitch taken", int'(key_open), 0);
        wait_edges(int'(LOCK));
        check(key_open === 1'b0, "R5 last locked edge", int'(key_open), 0);
        wait_edges(1);
        check(key_open === 1'b1, "R5 follow after lock", int'(key_open), 1);
        wait_edges(2 * int'(LOCK));

        // Seeded random segments with leading chatter
        for (int s = 0; s < 400; s++) begin
            int len;
            int chat;
            bit lvl;
            lvl  = 1'($urandom % 2);
            len  = 1 + int'($urandom % 40);
            chat = int'($urandom % 8);
            for (int c = 0; c < chat; c++) begin
                contact_raw = 1'($urandom % 2);
                @(negedge clk);
            end
            contact_raw = lvl;
            repeat (len) @(negedge clk);
        end
        contact_raw = 1'b1;
        wait_edges(3 * int'(LOCK));
        check(key_open === 1'b1, "R6 final open", int'(key_open), 1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule